// File: doc/BRIEF.md
# Serial Link Control and Status Register

This block holds the control flip-flops of a host-side serial link to a packet switch and builds the status word that goes back to the host when a command completes. The host writes a 16-bit command word. Individual bits in its low byte set or clear the host-ready relay flop, the loop-back test flop and the last-word flop. Other bits clear the whole interface or try to clear the sticky remote-down indication.

The block samples the remote ready line through a synchronizer. It latches every fall of that line until the host clears the latch, and the clear only takes effect while the remote side is ready again. It selects either the line receiver or the local transmitter as the receive source. When the post strobe is high it packs a software completion code over the hardware status byte.

Top module: `ifc_ctl_stat`

## Requirements
- R1: After reset, relay_on_o, test_mode_o, last_word_o and srst_o are 0 and the remote-down latch is 0. With post_en_i high, remote ready low and post_code_i = 0, post_word_o reads 16'h0003.
- R2: Command bit 7 sets the relay flop and bit 6 clears it. If both are 1 the flop clears. If both are 0 the flop keeps its value. The flop appears on relay_on_o one cycle after the write.
- R3: Command bit 5 sets the test-mode flop and bit 4 clears it, with the same clear-wins and hold rules as R2. The flop appears on test_mode_o.
- R4: rx_bit_o equals tx_bit_i while test mode is 1, and equals line_rx_i otherwise.
- R5: Command bit 1 sets last_word_o. last_ack_i clears it, and the clear wins when both arrive in the same cycle.
- R6: Command bit 2 (reset all) clears the relay, test and last-word flops and the remote-down latch, even if set bits are written in the same word. It raises srst_o for exactly one cycle after the write.
- R7: Status bit 1 (remote not ready) is the inverse of rmt_rdy_i, delayed by a two-stage synchronizer. Status bit 0 (host not ready) is the inverse of relay_on_o.
- R8: Status bit 2 (remote was down) sets on every fall of the synchronized ready line and stays set. Command bit 0 clears it only while the synchronized ready line is high. A fall in the same cycle still sets it.
- R9: While post_en_i is high, post_word_o[15:8] = post_code_i and post_word_o[7:3] = 0. The code values are 0 for OK, 1 for busy, 2 for overflow and 3 for zero length. While post_en_i is low, post_word_o is 0.
- R10: Command bits 15:8 and bit 3 have no effect. Data presented while cmd_we_i is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_data_i | input | 16 | Command word |
| last_ack_i | input | 1 | Transmitter has consumed the last-word flag |
| rmt_rdy_i | input | 1 | Remote ready line, asynchronous |
| tx_bit_i | input | 1 | Transmit serial bit, used for loop-back |
| line_rx_i | input | 1 | Receive bit from the line |
| post_en_i | input | 1 | Gate the status word onto post_word_o |
| post_code_i | input | 8 | Software completion code |
| rx_bit_o | output | 1 | Selected receive bit |
| relay_on_o | output | 1 | Host-ready relay flop |
| test_mode_o | output | 1 | Loop-back test flop |
| last_word_o | output | 1 | Last-word flop |
| srst_o | output | 1 | One-cycle reset pulse to the serial machines |
| post_word_o | output | 16 | Completion word: code over hardware status |

## Verification
Two functions can fall in the same cycle: setting a flop and clearing it, either through a paired command bit, through reset-all, or through last_ack_i arriving together with the set-last-word bit. The bench provokes each case with one command that carries both bits, or with the acknowledge driven in the write cycle. In every case it checks that the flop ends up cleared, and that srst_o pulses for reset-all. It also tries to clear the remote-down latch while the remote side is still down, and checks that the status bit stays set.

// File: rtl/ics_pkg.sv
package ics_pkg;
  // command bit positions (low byte of the command word)
  localparam int CB_RELAY_ON  = 7;
  localparam int CB_RELAY_OFF = 6;
  localparam int CB_TEST_ON   = 5;
  localparam int CB_TEST_OFF  = 4;
  localparam int CB_RST_ALL   = 2;
  localparam int CB_SET_LAST  = 1;
  localparam int CB_TRY_CLR   = 0;

  typedef enum logic [7:0] {
    PC_OK   = 8'd0,
    PC_BUSY = 8'd1,
    PC_OVF  = 8'd2,
    PC_ZLEN = 8'd3
  } post_code_e;

  typedef struct packed {
    logic relay_on;
    logic relay_off;
    logic test_on;
    logic test_off;
    logic rst_all;
    logic set_last;
    logic try_clr;
  } cmd_t;

  typedef struct packed {
    logic [4:0] pad;
    logic       was_down;
    logic       rmt_nrdy;
    logic       host_nrdy;
  } hw_stat_t;

  function automatic cmd_t decode_cmd(input logic we, input logic [7:0] b);
    cmd_t c;
    c.relay_on  = we & b[CB_RELAY_ON];
    c.relay_off = we & b[CB_RELAY_OFF];
    c.test_on   = we & b[CB_TEST_ON];
    c.test_off  = we & b[CB_TEST_OFF];
    c.rst_all   = we & b[CB_RST_ALL];
    c.set_last  = we & b[CB_SET_LAST];
    c.try_clr   = we & b[CB_TRY_CLR];
    return c;
  endfunction
endpackage

// File: rtl/ics_sync.sv
module ics_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ics_setclr.sv
module ics_setclr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end

  // R2 / R3 / R5 flop rules
  a_r2_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);
  a_r3_set_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> q_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/ics_down_latch.sv
module ics_down_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  input  logic try_clr_i,
  input  logic rst_all_i,
  output logic was_down_o
);
  logic prev_q;
  logic fall;

  assign fall = prev_q & ~rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= 1'b0;
      was_down_o <= 1'b0;
    end else begin
      prev_q <= rdy_i;
      if (fall)                                  was_down_o <= 1'b1;
      else if (rst_all_i || (try_clr_i && rdy_i)) was_down_o <= 1'b0;
    end
  end

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (was_down_o && !rst_all_i && !(try_clr_i && rdy_i)) |=> was_down_o);
  a_r8_clear_on_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (try_clr_i && rdy_i && prev_q) |=> !was_down_o);
endmodule

// File: rtl/ifc_ctl_stat.sv
module ifc_ctl_stat
  import ics_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              last_ack_i,
  input  logic              rmt_rdy_i,
  input  logic              tx_bit_i,
  input  logic              line_rx_i,
  input  logic              post_en_i,
  input  logic [DATA_W/2-1:0] post_code_i,
  output logic              rx_bit_o,
  output logic              relay_on_o,
  output logic              test_mode_o,
  output logic              last_word_o,
  output logic              srst_o,
  output logic [DATA_W-1:0] post_word_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NFLOP  = 3; // 0 relay, 1 test, 2 last word

  cmd_t       cmd;
  hw_stat_t   hw;
  logic       rdy_s;
  logic       was_down;
  logic [NFLOP-1:0] set_v, clr_v, q_v;

  assign cmd = decode_cmd(cmd_we_i, cmd_data_i[7:0]);

  assign set_v = {cmd.set_last, cmd.test_on, cmd.relay_on};
  assign clr_v = {last_ack_i | cmd.rst_all,
                  cmd.test_off | cmd.rst_all,
                  cmd.relay_off | cmd.rst_all};

  for (genvar i = 0; i < NFLOP; i++) begin : g_flop
    ics_setclr u_flop (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (q_v[i])
    );
  end

  assign relay_on_o  = q_v[0];
  assign test_mode_o = q_v[1];
  assign last_word_o = q_v[2];

  ics_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rmt_rdy_i),
    .q_o   (rdy_s)
  );

  ics_down_latch u_down (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rdy_i     (rdy_s),
    .try_clr_i (cmd.try_clr),
    .rst_all_i (cmd.rst_all),
    .was_down_o(was_down)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_o <= 1'b0;
    else         srst_o <= cmd.rst_all;
  end

  assign rx_bit_o = test_mode_o ? tx_bit_i : line_rx_i;

  always_comb begin
    hw           = '0;
    hw.was_down  = was_down;
    hw.rmt_nrdy  = ~rdy_s;
    hw.host_nrdy = ~relay_on_o;
  end

  assign post_word_o = post_en_i ? {post_code_i, HALF_W'(hw)} : '0;

  a_r6_reset_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_data_i[CB_RST_ALL]) |=>
      (srst_o && !relay_on_o && !test_mode_o && !last_word_o));
  a_r6_pulse_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_o && !$past(cmd_we_i && cmd_data_i[CB_RST_ALL])) |-> 1'b0);
  a_r5_ack_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_ack_i |=> !last_word_o);
endmodule

// File: tb/ifc_ctl_stat_tb_top.sv
module ifc_ctl_stat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {command, expected relay, expected test mode}
  localparam logic [17:0] VEC [NVEC] = '{
    {16'h0080, 1'b1, 1'b0},
    {16'h0000, 1'b1, 1'b0},
    {16'h0020, 1'b1, 1'b1},
    {16'hFF08, 1'b1, 1'b1},
    {16'h0040, 1'b0, 1'b1},
    {16'h00C0, 1'b0, 1'b1},
    {16'h0080, 1'b1, 1'b1},
    {16'h0030, 1'b1, 1'b0},
    {16'h00A0, 1'b1, 1'b1},
    {16'h0050, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic cmd_we = 0, last_ack = 0, rmt_rdy = 0, tx_bit = 0, line_rx = 0, post_en = 1;
  logic [15:0] cmd_data = 0;
  logic [7:0]  post_code = 0;
  logic rx_bit, relay_on, test_mode, last_word, srst;
  logic [15:0] post_word;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifc_ctl_stat dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_data_i(cmd_data),
    .last_ack_i(last_ack), .rmt_rdy_i(rmt_rdy), .tx_bit_i(tx_bit),
    .line_rx_i(line_rx), .post_en_i(post_en), .post_code_i(post_code),
    .rx_bit_o(rx_bit), .relay_on_o(relay_on), .test_mode_o(test_mode),
    .last_word_o(last_word), .srst_o(srst), .post_word_o(post_word)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on a falling edge; returns at the next falling edge (write taken)
  task automatic wr(input logic [15:0] d);
    @(negedge clk); cmd_we = 1; cmd_data = d;
    @(negedge clk); cmd_we = 0; cmd_data = 16'hFFFF;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    // R1 reset state
    chk("R1 post", post_word, 16'h0003);
    chk("R1 flops", {12'h0, relay_on, test_mode, last_word, srst}, 16'h0);
    rst_n = 1;
    idle(2);
    // R10 strobe low: data ignored
    cmd_data = 16'h00A2; idle(2);
    chk("R10 we low", {13'h0, relay_on, test_mode, last_word}, 16'h0);

    // R2 R3 R10 vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][17:2]);
      chk("R2 relay", {15'h0, relay_on}, {15'h0, VEC[i][1]});
      chk("R3 test", {15'h0, test_mode}, {15'h0, VEC[i][0]});
      chk("R7 host nrdy", {15'h0, post_word[0]}, {15'h0, ~VEC[i][1]});
    end

    // R4 loop-back select
    tx_bit = 1; line_rx = 0;
    wr(16'h0020); chk("R4 loop", {15'h0, rx_bit}, 16'h1);
    wr(16'h0010); chk("R4 line", {15'h0, rx_bit}, 16'h0);

    // R5 last word
    wr(16'h0002); chk("R5 set", {15'h0, last_word}, 16'h1);
    @(negedge clk); last_ack = 1; @(negedge clk); last_ack = 0;
    chk("R5 ack", {15'h0, last_word}, 16'h0);
    @(negedge clk); cmd_we = 1; cmd_data = 16'h0002; last_ack = 1;
    @(negedge clk); cmd_we = 0; last_ack = 0;
    chk("R5 ack wins", {15'h0, last_word}, 16'h0);

    // R7 synchronizer latency
    @(negedge clk); rmt_rdy = 1;
    @(negedge clk); chk("R7 one edge", {15'h0, post_word[1]}, 16'h1);
    @(negedge clk); chk("R7 two edges", {15'h0, post_word[1]}, 16'h0);

    // R8 sticky remote-down
    chk("R8 idle", {15'h0, post_word[2]}, 16'h0);
    @(negedge clk); rmt_rdy = 0;
    idle(4);
    chk("R8 set on fall", {15'h0, post_word[2]}, 16'h1);
    wr(16'h0001);
    chk("R8 clear refused while down", {15'h0, post_word[2]}, 16'h1);
    rmt_rdy = 1; idle(4);
    chk("R8 sticky after rise", {15'h0, post_word[2]}, 16'h1);
    wr(16'h0001);
    chk("R8 cleared", {15'h0, post_word[2]}, 16'h0);

    // R6 reset all beats sets in same word
    wr(16'h0082); wr(16'h0020);
    rmt_rdy = 0; idle(4);
    chk("R6 pre", {12'h0, relay_on, test_mode, last_word, post_word[2]}, 16'h000F);
    @(negedge clk); cmd_we = 1; cmd_data = 16'h00A6; rmt_rdy = 1;
    @(negedge clk); cmd_we = 0;
    chk("R6 cleared", {12'h0, relay_on, test_mode, last_word, post_word[2]}, 16'h0);
    chk("R6 pulse", {15'h0, srst}, 16'h1);
    @(negedge clk);
    chk("R6 pulse ends", {15'h0, srst}, 16'h0);

    // R9 post packing
    idle(3);
    for (int c = 0; c < 4; c++) begin
      post_code = 8'(c); #1;
      chk("R9 code", post_word, {8'(c), 8'h01});
    end
    post_en = 0; #1;
    chk("R9 gated off", post_word, 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule